// File: doc/BRIEF.md
# Snapshot-Read 64-Bit Tick Timer

This block is a system timer for a processor subsystem. A prescaler state machine turns the core clock into a slow tick. Each tick advances a free-running 64-bit count. Software reaches the block through a flat 32-bit register port that has a write strobe, a read strobe and a word index. Because a 64-bit value cannot be read in one access, software writes a command word. That write copies the whole count into a pair of snapshot registers in one cycle. Software can then read the two halves at leisure and they stay consistent.

Six 32-bit compare channels watch the low half of the count. Each channel has a sticky status flag, which is cleared by writing 1 to it, and an enable mask. The flag and the mask together drive one interrupt line per channel. The last channel also serves as a watchdog. When the watchdog is armed, a hit on that channel raises a one-cycle reset request. Software can preload the count one half at a time, for example to zero it at start-up or to restore a saved value.

The prescaler runs as a two-state machine with the states `PS_LOW` and `PS_HIGH`. Each state lasts one more cycle than the divider value. When `PS_LOW` runs out, the transition *half_done* moves the machine to `PS_HIGH`. When `PS_HIGH` runs out, the transition *period_done* returns it to `PS_LOW` and issues the tick. Otherwise a state holds and its cycle counter advances.

Top module: `snap_tick_timer`

## Requirements
- R1: After reset the count, snapshot, compare values, status, interrupt mask, watchdog arm bit and divider all read zero, and `irq` and `wdog_rst` are low. A read of word index 12 (the snapshot command) or 15 (unmapped) always returns zero.
- R2: With divider value D (word 11), the count advances by exactly 1 every 2*(D+1) clock cycles. The carry passes from the low half into the high half.
- R3: A write to word 0 replaces bits 31:0 of the count and a write to word 1 replaces bits 63:32. Either write takes priority over a tick that falls in the same cycle.
- R4: A write to word 12 with bit 0 set copies the 64-bit count, as it stands before that clock edge, into the snapshot registers. Word 13 holds the low half and word 14 the high half. Both keep that value until the next snapshot command.
- R5: Compare channel n (word 2+n) fires on the tick that makes the low count half equal to its value. That edge sets status bit n (word 8). The comparison wraps modulo 2^32.
- R6: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If a clear and a new hit for the same bit share a cycle, the bit stays set.
- R7: `irq[n]` is status bit n ANDed with mask bit n (word 9). Clearing a mask bit silences its line but does not stop the count.
- R8: When arm bit 0 of word 10 is set, a hit on channel 5 drives `wdog_rst` high for exactly the one cycle after status bit 5 sets. When the arm bit is clear, the hit sets only the status bit.
- R9: The compare, mask, arm and divider words read back what was written. Only bits 5:0 of the mask and bit 0 of the arm word are stored, and the other bits read as zero.
- R10: `reg_rdata` is combinational from `reg_re` and `reg_addr`, and it is zero while `reg_re` is low. Words 0 and 1 show the live count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 4 | Word index of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the same cycle as `reg_re` |
| irq | output | 6 | One interrupt line per compare channel |
| wdog_rst | output | 1 | One-cycle watchdog reset request |

## Verification
A prescaler stuck in one state stops the count. Two snapshots taken a whole number of periods apart then differ by zero instead of by that number of periods. A wrong half-period shows up as a wrong difference on the very first such pair. A compare or status fault appears within one tick as a missing or early status bit and interrupt. The race between clear and hit is driven on the exact edge of the hit, so the bit ends cleared if the clear wins. A watchdog pulse longer or shorter than one cycle is visible on the next cycle of `wdog_rst`.

// File: rtl/stt_pkg.sv
package stt_pkg;
    // word indices on the register port
    localparam int unsigned A_CNT_LO  = 0;
    localparam int unsigned A_CNT_HI  = 1;
    localparam int unsigned A_MATCH0  = 2;
    localparam int unsigned A_STATUS  = 8;
    localparam int unsigned A_IRQ_EN  = 9;
    localparam int unsigned A_WDOG_EN = 10;
    localparam int unsigned A_DIV     = 11;
    localparam int unsigned A_SNAP    = 12;
    localparam int unsigned A_SNAP_LO = 13;
    localparam int unsigned A_SNAP_HI = 14;

    typedef enum logic {
        PS_LOW  = 1'b0,
        PS_HIGH = 1'b1
    } ps_state_t;
endpackage

// File: rtl/stt_prescaler.sv
module stt_prescaler import stt_pkg::*; #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] div,
    output logic          tick
);
    ps_state_t     state_q, state_d;
    logic [DW-1:0] hcnt_q, hcnt_d;
    logic          half_done;

    assign half_done = (hcnt_q >= div);

    // next state
    always_comb begin
        state_d = state_q;
        hcnt_d  = hcnt_q + DW'(1);
        unique case (state_q)
            PS_LOW: begin
                if (half_done) begin
                    state_d = PS_HIGH;
                    hcnt_d  = '0;
                end
            end
            PS_HIGH: begin
                if (half_done) begin
                    state_d = PS_LOW;
                    hcnt_d  = '0;
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PS_LOW;
            hcnt_q  <= '0;
        end else begin
            state_q <= state_d;
            hcnt_q  <= hcnt_d;
        end
    end

    // outputs
    always_comb begin
        tick = 1'b0;
        unique case (state_q)
            PS_LOW:  tick = 1'b0;
            PS_HIGH: tick = half_done;
        endcase
    end
endmodule

// File: rtl/stt_counter.sv
module stt_counter #(
    parameter int DW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            wr_lo,
    input  logic            wr_hi,
    input  logic [DW-1:0]   wdata,
    output logic            bump,
    output logic [2*DW-1:0] cnt
);
    assign bump = tick && !wr_lo && !wr_hi;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else begin
            if (wr_lo) cnt[DW-1:0]    <= wdata;
            if (wr_hi) cnt[2*DW-1:DW] <= wdata;
            if (bump)  cnt            <= cnt + (2*DW)'(1);
        end
    end
endmodule

// File: rtl/stt_match_bank.sv
module stt_match_bank #(
    parameter int DW  = 32,
    parameter int NCH = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bump,
    input  logic [DW-1:0]     cnt_lo,
    input  logic [NCH*DW-1:0] match_flat,
    input  logic [NCH-1:0]    clr,
    output logic [NCH-1:0]    hit,
    output logic [NCH-1:0]    status
);
    logic [DW-1:0] cnt_next;

    assign cnt_next = cnt_lo + DW'(1);

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        assign hit[g] = bump && (cnt_next == match_flat[g*DW +: DW]);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      status[g] <= 1'b0;
            else if (hit[g]) status[g] <= 1'b1;
            else if (clr[g]) status[g] <= 1'b0;
        end
    end
endmodule

// File: rtl/snap_tick_timer.sv
module snap_tick_timer import stt_pkg::*; #(
    parameter int DW  = 32,
    parameter int AW  = 4,
    parameter int NCH = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           reg_we,
    input  logic           reg_re,
    input  logic [AW-1:0]  reg_addr,
    input  logic [DW-1:0]  reg_wdata,
    output logic [DW-1:0]  reg_rdata,
    output logic [NCH-1:0] irq,
    output logic           wdog_rst
);
    localparam int CW    = 2 * DW;
    localparam int WD_CH = NCH - 1;

    logic [DW-1:0]     div_q;
    logic [NCH-1:0]    inten_q;
    logic              wden_q;
    logic [DW-1:0]     match_q [NCH];
    logic [NCH*DW-1:0] match_flat;
    logic [CW-1:0]     cnt;
    logic [CW-1:0]     latched;
    logic              tick, bump;
    logic [NCH-1:0]    hit, status, clr;
    logic              wr_lo, wr_hi, snap_wr;

    assign wr_lo   = reg_we && (int'(reg_addr) == A_CNT_LO);
    assign wr_hi   = reg_we && (int'(reg_addr) == A_CNT_HI);
    assign snap_wr = reg_we && (int'(reg_addr) == A_SNAP) && reg_wdata[0];
    assign clr     = (reg_we && (int'(reg_addr) == A_STATUS)) ? reg_wdata[NCH-1:0] : '0;

    stt_prescaler #(.DW(DW)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .div   (div_q),
        .tick  (tick)
    );

    stt_counter #(.DW(DW)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .wr_lo (wr_lo),
        .wr_hi (wr_hi),
        .wdata (reg_wdata),
        .bump  (bump),
        .cnt   (cnt)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_match
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                match_q[g] <= '0;
            else if (reg_we && (int'(reg_addr) == A_MATCH0 + g))
                match_q[g] <= reg_wdata;
        end
        assign match_flat[g*DW +: DW] = match_q[g];
    end

    stt_match_bank #(.DW(DW), .NCH(NCH)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .bump       (bump),
        .cnt_lo     (cnt[DW-1:0]),
        .match_flat (match_flat),
        .clr        (clr),
        .hit        (hit),
        .status     (status)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q    <= '0;
            inten_q  <= '0;
            wden_q   <= 1'b0;
            latched  <= '0;
            wdog_rst <= 1'b0;
        end else begin
            if (reg_we && (int'(reg_addr) == A_DIV))     div_q   <= reg_wdata;
            if (reg_we && (int'(reg_addr) == A_IRQ_EN))  inten_q <= reg_wdata[NCH-1:0];
            if (reg_we && (int'(reg_addr) == A_WDOG_EN)) wden_q  <= reg_wdata[0];
            if (snap_wr)                                 latched <= cnt;
            wdog_rst <= hit[WD_CH] && wden_q;
        end
    end

    assign irq = status & inten_q;

    always_comb begin
        reg_rdata = '0;
        if (reg_re) begin
            if (int'(reg_addr) == A_CNT_LO)  reg_rdata = cnt[DW-1:0];
            if (int'(reg_addr) == A_CNT_HI)  reg_rdata = cnt[CW-1:DW];
            if (int'(reg_addr) == A_STATUS)  reg_rdata = DW'(status);
            if (int'(reg_addr) == A_IRQ_EN)  reg_rdata = DW'(inten_q);
            if (int'(reg_addr) == A_WDOG_EN) reg_rdata = DW'(wden_q);
            if (int'(reg_addr) == A_DIV)     reg_rdata = div_q;
            if (int'(reg_addr) == A_SNAP_LO) reg_rdata = latched[DW-1:0];
            if (int'(reg_addr) == A_SNAP_HI) reg_rdata = latched[CW-1:DW];
            for (int i = 0; i < NCH; i++)
                if (int'(reg_addr) == A_MATCH0 + i) reg_rdata = match_q[i];
        end
    end
endmodule

// File: rtl/stt_checker.sv
module stt_checker import stt_pkg::*; #(
    parameter int DW  = 32,
    parameter int AW  = 4,
    parameter int NCH = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic            reg_we,
    input logic [AW-1:0]   reg_addr,
    input logic [DW-1:0]   reg_wdata,
    input logic            tick,
    input logic [2*DW-1:0] cnt,
    input logic [2*DW-1:0] latched,
    input logic [NCH-1:0]  status,
    input logic [NCH-1:0]  irq,
    input logic            wden_q,
    input logic            wdog_rst
);
    logic cnt_wr, snap_cmd, st_wr;

    assign cnt_wr   = reg_we && (int'(reg_addr) == A_CNT_LO || int'(reg_addr) == A_CNT_HI);
    assign snap_cmd = reg_we && (int'(reg_addr) == A_SNAP) && reg_wdata[0];
    assign st_wr    = reg_we && (int'(reg_addr) == A_STATUS);

    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_wr) |=> (cnt == $past(cnt) + (2*DW)'(1)));

    assert_count_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !cnt_wr) |=> (cnt == $past(cnt)));

    assert_tick_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    assert_preload_lo_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && int'(reg_addr) == A_CNT_LO) |=> (cnt[DW-1:0] == $past(reg_wdata)));

    assert_snap_take_R4: assert property (@(posedge clk) disable iff (!rst_n)
        snap_cmd |=> (latched == $past(cnt)));

    assert_snap_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !snap_cmd |=> $stable(latched));

    assert_status_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !st_wr |=> ((status & $past(status)) == $past(status)));

    assert_irq_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
        |irq |-> ((irq & ~status) == '0));

    assert_wdog_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_rst |=> !wdog_rst);

    assert_wdog_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_rst |-> (wden_q && status[NCH-1]));
endmodule

bind snap_tick_timer stt_checker #(.DW(DW), .AW(AW), .NCH(NCH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .tick      (tick),
    .cnt       (cnt),
    .latched   (latched),
    .status    (status),
    .irq       (irq),
    .wden_q    (wden_q),
    .wdog_rst  (wdog_rst)
);

// File: tb/test_snap_tick_timer.sv
module test_snap_tick_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic        reg_re = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [5:0]  irq;
    logic        wdog_rst;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk; // 125 MHz

    snap_tick_timer i_snap_tick_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_re    (reg_re),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq),
        .wdog_rst  (wdog_rst)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // starts and ends just after a falling edge; uses one rising edge
    task automatic wr(input int a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = 4'(a); reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        reg_re = 1'b1; reg_addr = 4'(a);
        #1;
        d = reg_rdata;
        reg_re = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        for (int a = 0; a < 16; a++) begin
            rd(a, v);
            check(v == 0, $sformatf("R1 reset word %0d", a), v, 0);
        end
        check(irq == 0 && wdog_rst == 0, "R1 outputs at reset", {irq, wdog_rst}, 0);
        reg_re = 1'b1; reg_addr = 4'd1; #1;
        reg_re = 1'b0; #1;
        check(reg_rdata == 0, "R10 rdata zero without read strobe", reg_rdata, 0);
    endtask

    task automatic t_readback;
        logic [31:0] v;
        for (int i = 0; i < 6; i++) wr(2 + i, 32'hA500_0000 + 32'(i));
        for (int i = 0; i < 6; i++) begin
            rd(2 + i, v);
            check(v == 32'hA500_0000 + 32'(i), "R9 compare readback", v, 32'hA500_0000 + 32'(i));
        end
        wr(9, 32'hFFFF_FFFF); rd(9, v);
        check(v == 32'h3F, "R9 mask readback", v, 32'h3F);
        wr(10, 32'hFFFF_FFFF); rd(10, v);
        check(v == 32'h1, "R9 arm readback", v, 1);
        wr(11, 32'h0000_1234); rd(11, v);
        check(v == 32'h1234, "R9 divider readback", v, 32'h1234);
        rd(15, v);
        check(v == 0, "R1 unmapped word", v, 0);
        rd(12, v);
        check(v == 0, "R1 snapshot command reads zero", v, 0);
        wr(9, 0); wr(10, 0); wr(11, 0);
        for (int i = 0; i < 6; i++) wr(2 + i, 32'hFFFF_0000);
        wr(8, 32'h3F);
    endtask

    task automatic measure(input int div, input int k, input string tag);
        logic [31:0] a, b;
        int p;
        p = 2 * (div + 1);
        wr(11, 32'(div));
        idle(3 * p);
        wr(12, 1); rd(13, a);
        idle(k * p - 1);
        wr(12, 1); rd(13, b);
        check(b - a == 32'(k), tag, b - a, k);
    endtask

    task automatic t_prescale;
        measure(0, 20, "R2 tick rate div 0");
        measure(2, 10, "R2 tick rate div 2");
        measure(5, 4, "R2 tick rate div 5");
        wr(11, 0);
    endtask

    task automatic t_preload;
        logic [31:0] v;
        wr(11, 3);
        wr(0, 32'h1234_5678);
        wr(1, 32'h0000_00AB);
        wr(12, 1);
        rd(14, v);
        check(v == 32'hAB, "R3 preload high", v, 32'hAB);
        rd(13, v);
        check(v == 32'h1234_5678 || v == 32'h1234_5679, "R3 preload low", v, 32'h1234_5678);
        wr(11, 0);
    endtask

    task automatic t_snap_hold;
        logic [31:0] a, b, live;
        wr(12, 1);
        rd(13, a);
        idle(30);
        rd(13, b);
        check(a == b, "R4 snapshot holds", b, a);
        rd(0, live);
        check(live - a >= 32'd14, "R4 live count moved on (R10)", live - a, 15);
    endtask

    task automatic t_match;
        logic [31:0] v;
        wr(8, 32'h3F);
        wr(9, 32'h01);
        wr(2, 32'h0000_0100);
        wr(0, 32'h0000_00F0);
        idle(20);
        rd(8, v);
        check(v[0] == 0, "R5 no hit before equality", v[0], 0);
        idle(20);
        rd(8, v);
        check(v[0] == 1, "R5 hit on equality", v[0], 1);
        check(irq[0] == 1, "R7 irq follows enabled status", irq[0], 1);
        // wrap across 2^32
        wr(3, 32'h0000_0002);
        wr(0, 32'hFFFF_FFFD);
        wr(1, 32'h0000_0007);
        idle(20);
        rd(8, v);
        check(v[1] == 1, "R5 hit after wrap", v[1], 1);
        rd(1, v);
        check(v == 32'h8, "R2 carry into high half", v, 8);
    endtask

    task automatic t_irq_mask;
        logic [31:0] a, b;
        wr(9, 0);
        #1;
        check(irq[0] == 0, "R7 masked line low", irq[0], 0);
        rd(0, a); idle(10); rd(0, b);
        check(b != a, "R7 count runs while masked", b, a + 5);
        wr(9, 1);
        #1;
        check(irq[0] == 1, "R7 unmasked line high", irq[0], 1);
    endtask

    task automatic t_clear;
        logic [31:0] v;
        logic [31:0] x;
        x = 32'h0000_5000;
        wr(8, 32'h01);
        rd(8, v);
        check(v[1:0] == 2'b10, "R6 clear bit 0 only", v[1:0], 2'b10);
        wr(8, 32'h3F);
        wr(2, x + 32'd2);
        wr(0, x);
        idle(1);
        rd(0, v);
        check(v == x || v == x + 1, "R6 phase probe", v, x);
        if (v == x + 1) idle(1);
        else idle(2);
        wr(8, 32'h01);
        rd(8, v);
        check(v[0] == 1, "R6 hit wins over clear", v[0], 1);
        wr(8, 32'h01);
        rd(8, v);
        check(v[0] == 0, "R6 clear in quiet cycle", v[0], 0);
    endtask

    task automatic watch_wdog(input bit armed, input string tag);
        logic [31:0] v;
        int pulses;
        pulses = 0;
        wr(8, 32'h3F);
        wr(10, 32'(armed));
        wr(7, 32'h0000_9000);
        wr(0, 32'h0000_8FF8);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (wdog_rst) pulses++;
        end
        check(pulses == (armed ? 1 : 0), tag, pulses, armed ? 1 : 0);
        rd(8, v);
        check(v[5] == 1, "R8 channel 5 status set", v[5], 1);
    endtask

    task automatic t_wdog;
        watch_wdog(1'b1, "R8 one-cycle reset request when armed");
        watch_wdog(1'b0, "R8 no reset request when disarmed");
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #1;
        t_reset;
        #20;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_readback;
        t_prescale;
        t_preload;
        t_snap_hold;
        t_match;
        t_irq_mask;
        t_clear;
        t_wdog;
        finish_run;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run hung, actual timeout expected completion");
        finish_run;
    end
endmodule